// File: doc/BRIEF.md
# Core-to-Wishbone Byte-Lane Bridge

This block turns single load/store requests from a simple processor data port into classic Wishbone cycles on a 32-bit bus with byte granularity. The core offers a byte address, a two-bit size code, write data, a write flag and a one-cycle request pulse. The bridge works out the byte-lane select from the low address bits and the size. It moves write data onto the matching lanes and holds the bus cycle until the target acknowledges. On a read it returns the selected bytes right-justified, together with a one-cycle done pulse.

Lane placement is big-endian by default: byte offset 0 lives in the most significant lane. A parameter mirrors the mapping for little-endian systems. Only one transfer is outstanding at a time. A request that arrives while a cycle is open is dropped, so the core must wait for done before it issues the next one.

Top module: `cwb_bridge`

## Requirements
- R1: After reset and whenever no cycle is open, every bus output is zero: address, data, select, write, strobe and cycle. The cycle-type tag (3 bits) and burst-type tag (2 bits) are always 000 and 00.
- R2: A request is taken only while the bridge is idle. Cycle and strobe go high on the clock edge after the request. A request pulsed while a cycle is open, including in the acknowledge cycle, starts no new cycle.
- R3: While a cycle is open and acknowledge is low, cycle, strobe, address, select, data and write stay unchanged. Strobe always equals cycle. The bus address is the byte address with its two lowest bits removed.
- R4: Size code 00 (byte), big-endian: offsets 0,1,2,3 give select 1000,0100,0010,0001, and write bits 7:0 go to bus bits 31:24, 23:16, 15:8 and 7:0 respectively. All other lanes are zero.
- R5: Size code 01 (halfword), big-endian: offset 0 or 1 gives select 1100 with write bits 15:0 on bus bits 31:16. Offset 2 or 3 gives select 0011 with write bits 15:0 on bus bits 15:0.
- R6: Size code 10 (word) gives select 1111 and passes the write data unchanged. Size code 11 gives select 0000 and zero write data. A read drives zero write data.
- R7: On the acknowledge of a read, the returned data is registered as follows. A single-lane select returns that lane in bits 7:0. Select 1100 or 0011 returns that half in bits 15:0. Select 1111 returns the whole word. Unused upper bits are zero.
- R8: A read whose select is 0000 (size code 11) returns zero.
- R9: The clock edge that samples acknowledge high closes the cycle. Done is high for exactly the following cycle, and the read data is valid there.
- R10: With the endianness parameter cleared, the byte mapping is mirrored (offset k selects lane k). Halfword offsets 0 and 1 select 0011, and offsets 2 and 3 select 1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | One-cycle transfer request |
| core_addr | input | ADDR_W | Byte address |
| core_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| core_we | input | 1 | 1 = write, 0 = read |
| core_wdata | input | DATA_W | Right-justified write data |
| core_rdata | output | DATA_W | Right-justified read data |
| core_done | output | 1 | One-cycle completion pulse |
| wb_adr_o | output | ADDR_W-2 | Word address |
| wb_dat_o | output | DATA_W | Lane-steered write data |
| wb_dat_i | input | DATA_W | Read data from target |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | DATA_W/GRAN | Byte-lane select |
| wb_stb_o | output | 1 | Strobe |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_cti_o | output | 3 | Cycle-type tag, constant classic |
| wb_bte_o | output | 2 | Burst-type tag, constant zero |
| wb_ack_i | input | 1 | Acknowledge from target |

## Verification
Cycle completion and request acceptance can fall in the same clock: the core may pulse a new request in the very cycle the target acknowledges. The bench provokes this by raising the request together with acknowledge on chosen transfers. It then judges that the bus stays idle in both the done cycle and the cycle after it, and that the scoreboard never sees an unexpected extra cycle. Wait states of several lengths are mixed in, so that hold stability is judged against the scoreboard item across more than one cycle.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_BAD  = 2'b11
   } size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } state_e;
endpackage

// File: rtl/cwb_lane_sel.sv
module cwb_lane_sel #(
   parameter int LANES      = 4,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int OFF_W     = $clog2(LANES)
) (
   input  logic [OFF_W-1:0]  offset,
   input  cwb_pkg::size_e    size,
   output logic [LANES-1:0]  sel
);
   logic [OFF_W-1:0] byte_lane;
   logic [OFF_W-2:0] pair_raw;
   logic [OFF_W-2:0] pair_idx;

   assign pair_raw = offset[OFF_W-1:1];

   generate
      if (BIG_ENDIAN) begin : g_big
         assign byte_lane = ~offset;
         assign pair_idx  = ~pair_raw;
      end else begin : g_little
         assign byte_lane = offset;
         assign pair_idx  = pair_raw;
      end
   endgenerate

   always_comb begin
      case (size)
         cwb_pkg::SZ_BYTE: sel = LANES'(1) << byte_lane;
         cwb_pkg::SZ_HALF: sel = LANES'(3) << {pair_idx, 1'b0};
         cwb_pkg::SZ_WORD: sel = '1;
         default:          sel = '0;
      endcase
   end
endmodule

// File: rtl/cwb_wr_steer.sv
module cwb_wr_steer #(
   parameter int DATA_W = 32,
   parameter int GRAN   = 8,
   localparam int LANES = DATA_W / GRAN
) (
   input  logic [LANES-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] lanes
);
   // Selected lanes take consecutive slices of the right-justified data,
   // lowest selected lane first.
   always_comb begin
      int rank;
      lanes = '0;
      rank  = 0;
      for (int i = 0; i < LANES; i++) begin
         if (sel[i]) begin
            lanes[i*GRAN +: GRAN] = wdata[rank*GRAN +: GRAN];
            rank++;
         end
      end
   end
endmodule

// File: rtl/cwb_rd_align.sv
module cwb_rd_align #(
   parameter int DATA_W = 32,
   parameter int GRAN   = 8,
   localparam int LANES = DATA_W / GRAN
) (
   input  logic [LANES-1:0]  sel,
   input  logic [DATA_W-1:0] bus,
   output logic [DATA_W-1:0] data
);
   logic sel_ok;

   always_comb begin
      sel_ok = ($countones(sel) == 1) || (&sel);
      for (int p = 0; p < LANES/2; p++) begin
         if (sel == (LANES'(3) << (2*p))) sel_ok = 1'b1;
      end
   end

   always_comb begin
      int rank;
      data = '0;
      rank = 0;
      if (sel_ok) begin
         for (int i = 0; i < LANES; i++) begin
            if (sel[i]) begin
               data[rank*GRAN +: GRAN] = bus[i*GRAN +: GRAN];
               rank++;
            end
         end
      end
   end
endmodule

// File: rtl/cwb_bridge.sv
module cwb_bridge #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int GRAN       = 8,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int LANES     = DATA_W / GRAN,
   localparam int LSB_W     = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    core_req,
   input  logic [ADDR_W-1:0]       core_addr,
   input  logic [1:0]              core_size,
   input  logic                    core_we,
   input  logic [DATA_W-1:0]       core_wdata,
   output logic [DATA_W-1:0]       core_rdata,
   output logic                    core_done,
   output logic [ADDR_W-LSB_W-1:0] wb_adr_o,
   output logic [DATA_W-1:0]       wb_dat_o,
   input  logic [DATA_W-1:0]       wb_dat_i,
   output logic                    wb_we_o,
   output logic [LANES-1:0]        wb_sel_o,
   output logic                    wb_stb_o,
   output logic                    wb_cyc_o,
   output logic [2:0]              wb_cti_o,
   output logic [1:0]              wb_bte_o,
   input  logic                    wb_ack_i
);
   import cwb_pkg::*;

   generate
      if (LANES != 4 || LANES * GRAN != DATA_W) begin : g_bad_cfg
         $error("cwb_bridge: DATA_W/GRAN must give exactly four lanes");
      end
      if (ADDR_W <= LSB_W) begin : g_bad_addr
         $error("cwb_bridge: ADDR_W too small");
      end
   endgenerate

   state_e                  state_q;
   logic [ADDR_W-LSB_W-1:0] adr_q;
   logic [LANES-1:0]        sel_q;
   logic [DATA_W-1:0]       dat_q;
   logic                    we_q;
   logic [DATA_W-1:0]       rdata_q;
   logic                    done_q;

   logic [LANES-1:0]        sel_d;
   logic [DATA_W-1:0]       dat_d;
   logic [DATA_W-1:0]       rdata_d;

   cwb_lane_sel #(.LANES(LANES), .BIG_ENDIAN(BIG_ENDIAN)) u_lane_sel (
      .offset (core_addr[LSB_W-1:0]),
      .size   (size_e'(core_size)),
      .sel    (sel_d)
   );

   cwb_wr_steer #(.DATA_W(DATA_W), .GRAN(GRAN)) u_wr_steer (
      .sel   (sel_d),
      .wdata (core_wdata),
      .lanes (dat_d)
   );

   cwb_rd_align #(.DATA_W(DATA_W), .GRAN(GRAN)) u_rd_align (
      .sel  (sel_q),
      .bus  (wb_dat_i),
      .data (rdata_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         adr_q   <= '0;
         sel_q   <= '0;
         dat_q   <= '0;
         we_q    <= 1'b0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (core_req) begin
                  state_q <= ST_BUSY;
                  adr_q   <= core_addr[ADDR_W-1:LSB_W];
                  sel_q   <= sel_d;
                  dat_q   <= core_we ? dat_d : '0;
                  we_q    <= core_we;
               end
            end
            default: begin
               if (wb_ack_i) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  if (!we_q) rdata_q <= rdata_d;
                  adr_q   <= '0;
                  sel_q   <= '0;
                  dat_q   <= '0;
                  we_q    <= 1'b0;
               end
            end
         endcase
      end
   end

   assign wb_cyc_o   = (state_q == ST_BUSY);
   assign wb_stb_o   = (state_q == ST_BUSY);
   assign wb_adr_o   = adr_q;
   assign wb_sel_o   = sel_q;
   assign wb_dat_o   = dat_q;
   assign wb_we_o    = we_q;
   assign wb_cti_o   = 3'b000;
   assign wb_bte_o   = 2'b00;
   assign core_rdata = rdata_q;
   assign core_done  = done_q;
endmodule

// File: rtl/cwb_bridge_chk.sv
module cwb_bridge_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int GRAN   = 8,
   localparam int LANES = DATA_W / GRAN,
   localparam int LSB_W = $clog2(LANES)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    core_req,
   input logic [DATA_W-1:0]       core_rdata,
   input logic                    core_done,
   input logic [ADDR_W-LSB_W-1:0] wb_adr_o,
   input logic [DATA_W-1:0]       wb_dat_o,
   input logic                    wb_we_o,
   input logic [LANES-1:0]        wb_sel_o,
   input logic                    wb_stb_o,
   input logic                    wb_cyc_o,
   input logic [2:0]              wb_cti_o,
   input logic [1:0]              wb_bte_o,
   input logic                    wb_ack_i
);
   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_cyc_o |-> (wb_sel_o == '0 && wb_adr_o == '0 && wb_dat_o == '0 && !wb_we_o && !wb_stb_o));

   assert_tags_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cti_o == 3'b000 && wb_bte_o == 2'b00);

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_req && !wb_cyc_o |=> wb_cyc_o);

   assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o && wb_ack_i |=> !wb_cyc_o);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o && !wb_ack_i |=> wb_cyc_o && $stable(wb_sel_o) && $stable(wb_adr_o)
                                && $stable(wb_dat_o) && $stable(wb_we_o));

   assert_stb_cyc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stb_o == wb_cyc_o);

   assert_sel_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wb_sel_o) == 0 || $countones(wb_sel_o) == 1 ||
      $countones(wb_sel_o) == 2 || $countones(wb_sel_o) == LANES);

   assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o && wb_ack_i && !wb_we_o && wb_sel_o == '0 |=> core_rdata == '0);

   assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cyc_o && wb_ack_i |=> core_done);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_done |=> !core_done);

   assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_done |-> !wb_cyc_o);
endmodule

bind cwb_bridge cwb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN(GRAN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_req   (core_req),
   .core_rdata (core_rdata),
   .core_done  (core_done),
   .wb_adr_o   (wb_adr_o),
   .wb_dat_o   (wb_dat_o),
   .wb_we_o    (wb_we_o),
   .wb_sel_o   (wb_sel_o),
   .wb_stb_o   (wb_stb_o),
   .wb_cyc_o   (wb_cyc_o),
   .wb_cti_o   (wb_cti_o),
   .wb_bte_o   (wb_bte_o),
   .wb_ack_i   (wb_ack_i)
);

// File: tb/cwb_bridge_bench.sv
`timescale 1ns/1ps
module cwb_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_req = 1'b0;
   logic [31:0] core_addr = '0;
   logic [1:0]  core_size = '0;
   logic        core_we = 1'b0;
   logic [31:0] core_wdata = '0;
   logic [31:0] wb_dat_i = '0;
   logic        wb_ack_i = 1'b0;

   logic [31:0] core_rdata, le_rdata, wb_dat_o, le_dat;
   logic        core_done, le_done, wb_we_o, le_we, wb_stb_o, le_stb, wb_cyc_o, le_cyc;
   logic [29:0] wb_adr_o, le_adr;
   logic [3:0]  wb_sel_o, le_sel;
   logic [2:0]  wb_cti_o, le_cti;
   logic [1:0]  wb_bte_o, le_bte;

   always #4 clk = ~clk;

   cwb_bridge u_cwb_bridge (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
      .core_size(core_size), .core_we(core_we), .core_wdata(core_wdata),
      .core_rdata(core_rdata), .core_done(core_done), .wb_adr_o(wb_adr_o),
      .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_we_o(wb_we_o),
      .wb_sel_o(wb_sel_o), .wb_stb_o(wb_stb_o), .wb_cyc_o(wb_cyc_o),
      .wb_cti_o(wb_cti_o), .wb_bte_o(wb_bte_o), .wb_ack_i(wb_ack_i)
   );

   cwb_bridge #(.BIG_ENDIAN(1'b0)) u_cwb_bridge_le (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
      .core_size(core_size), .core_we(core_we), .core_wdata(core_wdata),
      .core_rdata(le_rdata), .core_done(le_done), .wb_adr_o(le_adr),
      .wb_dat_o(le_dat), .wb_dat_i(wb_dat_i), .wb_we_o(le_we),
      .wb_sel_o(le_sel), .wb_stb_o(le_stb), .wb_cyc_o(le_cyc),
      .wb_cti_o(le_cti), .wb_bte_o(le_bte), .wb_ack_i(wb_ack_i)
   );

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [29:0] adr;
      logic        we;
      logic [3:0]  sel_be, sel_le;
      logic [31:0] dat_be, dat_le;
      logic [31:0] rd_be, rd_le;
   } item_t;

   item_t bus_q[$];
   item_t res_q[$];
   item_t cur;
   logic  prev_cyc = 1'b0;

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected values from the requirement tables
   function automatic logic [3:0] exp_sel(input logic [1:0] off, input logic [1:0] size, input bit big);
      logic hi;
      case (size)
         2'b00: return big ? (4'b1000 >> off) : (4'b0001 << off);
         2'b01: begin
            hi = big ? (off < 2) : (off >= 2);
            return hi ? 4'b1100 : 4'b0011;
         end
         2'b10: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [31:0] exp_wdat(input logic [3:0] sel, input logic [31:0] wd);
      case (sel)
         4'b0001: return {24'h0, wd[7:0]};
         4'b0010: return {16'h0, wd[7:0], 8'h0};
         4'b0100: return {8'h0, wd[7:0], 16'h0};
         4'b1000: return {wd[7:0], 24'h0};
         4'b0011: return {16'h0, wd[15:0]};
         4'b1100: return {wd[15:0], 16'h0};
         4'b1111: return wd;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(input logic [3:0] sel, input logic [31:0] b);
      case (sel)
         4'b0001: return {24'h0, b[7:0]};
         4'b0010: return {24'h0, b[15:8]};
         4'b0100: return {24'h0, b[23:16]};
         4'b1000: return {24'h0, b[31:24]};
         4'b0011: return {16'h0, b[15:0]};
         4'b1100: return {16'h0, b[31:16]};
         4'b1111: return b;
         default: return 32'h0;
      endcase
   endfunction

   task automatic access(input logic [31:0] addr, input logic [1:0] size, input logic we,
                         input logic [31:0] wd, input logic [31:0] bus, input int waits,
                         input bit poke, input string tag);
      item_t it;
      it.adr    = addr[31:2];
      it.we     = we;
      it.sel_be = exp_sel(addr[1:0], size, 1'b1);
      it.sel_le = exp_sel(addr[1:0], size, 1'b0);
      it.dat_be = we ? exp_wdat(it.sel_be, wd) : 32'h0;
      it.dat_le = we ? exp_wdat(it.sel_le, wd) : 32'h0;
      it.rd_be  = exp_rd(it.sel_be, bus);
      it.rd_le  = exp_rd(it.sel_le, bus);
      bus_q.push_back(it);
      res_q.push_back(it);
      @(negedge clk);
      core_req = 1'b1; core_addr = addr; core_size = size; core_we = we; core_wdata = wd;
      @(negedge clk);
      core_req = 1'b0;
      check(wb_cyc_o === 1'b1, {tag, " R2 cycle opens after request"}, {31'h0, wb_cyc_o}, 32'h1);
      repeat (waits) @(negedge clk);
      wb_ack_i = 1'b1; wb_dat_i = bus;
      if (poke) begin
         core_req = 1'b1; core_addr = 32'h0000_0F00; core_size = 2'b10; core_we = 1'b1;
      end
      @(negedge clk);
      wb_ack_i = 1'b0; core_req = 1'b0; wb_dat_i = 32'hDEAD_BEEF;
      check(core_done === 1'b1, {tag, " R9 done after ack"}, {31'h0, core_done}, 32'h1);
      check(wb_cyc_o === 1'b0, {tag, " R9 cycle closed with ack"}, {31'h0, wb_cyc_o}, 32'h0);
      @(negedge clk);
      check(core_done === 1'b0, {tag, " R9 done lasts one cycle"}, {31'h0, core_done}, 32'h0);
      check(wb_cyc_o === 1'b0, {tag, " R2 no cycle from request during busy"}, {31'h0, wb_cyc_o}, 32'h0);
      check(wb_sel_o === 4'h0 && wb_dat_o === 32'h0, {tag, " R1 idle outputs zero"}, {28'h0, wb_sel_o}, 32'h0);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         check(wb_cti_o === 3'b000 && wb_bte_o === 2'b00, "R1 tags zero", {27'h0, wb_cti_o, wb_bte_o}, 32'h0);
         check(wb_stb_o === wb_cyc_o, "R3 strobe follows cycle", {31'h0, wb_stb_o}, {31'h0, wb_cyc_o});
         if (wb_cyc_o && !prev_cyc) begin
            if (bus_q.size() == 0) begin
               check(1'b0, "R2 unexpected bus cycle", 32'h1, 32'h0);
            end else begin
               cur = bus_q.pop_front();
               check(wb_adr_o === cur.adr, "R3 word address", {2'b0, wb_adr_o}, {2'b0, cur.adr});
               check(wb_we_o === cur.we, "R3 write flag", {31'h0, wb_we_o}, {31'h0, cur.we});
               check(wb_sel_o === cur.sel_be, "R4 R5 R6 select", {28'h0, wb_sel_o}, {28'h0, cur.sel_be});
               check(wb_dat_o === cur.dat_be, "R4 R5 R6 write lanes", wb_dat_o, cur.dat_be);
               check(le_sel === cur.sel_le, "R10 mirrored select", {28'h0, le_sel}, {28'h0, cur.sel_le});
               check(le_dat === cur.dat_le, "R10 mirrored lanes", le_dat, cur.dat_le);
            end
         end else if (wb_cyc_o && prev_cyc) begin
            check(wb_sel_o === cur.sel_be && wb_dat_o === cur.dat_be && wb_adr_o === cur.adr,
                  "R3 held during wait", wb_dat_o, cur.dat_be);
         end
         if (core_done) begin
            if (res_q.size() == 0) begin
               check(1'b0, "R9 unexpected done", 32'h1, 32'h0);
            end else begin
               item_t r;
               r = res_q.pop_front();
               if (!r.we) begin
                  check(core_rdata === r.rd_be, (r.sel_be == 4'h0) ? "R8 invalid read zero" : "R7 read align",
                        core_rdata, r.rd_be);
                  check(le_rdata === r.rd_le, "R10 mirrored read align", le_rdata, r.rd_le);
               end
            end
         end
         prev_cyc = wb_cyc_o;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(wb_cyc_o === 1'b0 && core_done === 1'b0, "R1 reset cycle/done", {30'h0, wb_cyc_o, core_done}, 32'h0);
      check(wb_sel_o === 4'h0 && wb_adr_o === 30'h0 && wb_dat_o === 32'h0 && wb_we_o === 1'b0,
            "R1 reset bus outputs", {28'h0, wb_sel_o}, 32'h0);
      check(core_rdata === 32'h0, "R1 reset read data", core_rdata, 32'h0);
      rst_n = 1'b1;
      access(32'h1000_0000, 2'b00, 1'b1, 32'h0000_00A5, 32'h0, 0, 1'b0, "R4 byte off0");
      access(32'h1000_0001, 2'b00, 1'b1, 32'h0000_00B6, 32'h0, 1, 1'b0, "R4 byte off1");
      access(32'h1000_0002, 2'b00, 1'b1, 32'h0000_00C7, 32'h0, 2, 1'b0, "R4 byte off2");
      access(32'h1000_0003, 2'b00, 1'b1, 32'hFFFF_FFD8, 32'h0, 0, 1'b1, "R4 byte off3");
      access(32'h2000_0005, 2'b01, 1'b1, 32'h0000_BEEF, 32'h0, 3, 1'b0, "R5 half off1");
      access(32'h2000_0006, 2'b01, 1'b1, 32'h1234_CAFE, 32'h0, 0, 1'b1, "R5 half off2");
      access(32'h3000_0008, 2'b10, 1'b1, 32'h8765_4321, 32'h0, 1, 1'b0, "R6 word");
      access(32'h3000_000D, 2'b11, 1'b1, 32'hFFFF_FFFF, 32'h0, 0, 1'b0, "R6 invalid size");
      access(32'h4000_0001, 2'b00, 1'b0, 32'h0, 32'h1122_3344, 2, 1'b1, "R7 read byte off1");
      access(32'h4000_0003, 2'b00, 1'b0, 32'h0, 32'hA1B2_C3D4, 0, 1'b0, "R7 read byte off3");
      access(32'h4000_0003, 2'b01, 1'b0, 32'h0, 32'h1122_3344, 1, 1'b0, "R7 read half off3");
      access(32'h4000_0000, 2'b01, 1'b0, 32'h0, 32'h5566_7788, 0, 1'b1, "R7 read half off0");
      access(32'h4000_0004, 2'b10, 1'b0, 32'h0, 32'hCAFE_F00D, 4, 1'b0, "R7 read word");
      access(32'h4000_0002, 2'b11, 1'b0, 32'h0, 32'hFFFF_FFFF, 1, 1'b0, "R8 read invalid");
      repeat (2) @(negedge clk);
      check(bus_q.size() == 0 && res_q.size() == 0, "R2 all items consumed",
            bus_q.size() + res_q.size(), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule